// File: doc/BRIEF.md
# Byte-Lane Static Memory Model

This block is a synthesizable, clock-driven stand-in for a 16-bit static memory that is controlled the way an asynchronous part is. It has two chip selects of opposite polarity, an active-low write strobe, an active-low output gate and an active-low enable for each byte lane. Each lane is a separate 8-bit array with a parameterized depth. The block works out one of four modes from the controls: off, selected but quiet, read or write. It then writes or reads only the lanes that are enabled.

The controls and the address are sampled on the rising clock edge. A write lands in the array at that edge. Read data and the per-lane drive flags appear one clock after the sampling edge, which stands in for access time. In place of real tri-state pads, each lane has a drive flag. When a lane's flag is low, that lane's read data is held at zero.

Top module: `lane_sram`

## Requirements
- R1: When `sel_n` is high or `sel_p` is low, both drive flags are low one clock later and no lane is written.
- R2: When `lo_n` and `hi_n` are both high, the block acts as deselected: both drive flags are low one clock later and nothing is written.
- R3: `lo_n` low enables bits 7:0 and `hi_n` low enables bits 15:8. Each enable is independent of the other, and a write changes only the enabled lanes.
- R4: When the block is selected with `wr_n` high and `oe_n` low, each enabled lane raises its drive flag one clock after the sampling edge and shows the stored byte for the sampled address.
- R5: When the block is selected with `wr_n` and `oe_n` both high, both drive flags are low one clock later and the array is unchanged.
- R6: Write takes priority over the output gate. With `wr_n` low, the enabled lanes are written whatever the level of `oe_n`, and both drive flags are low one clock later.
- R7: After reset, and on any lane whose drive flag is low, that lane's read data is zero.
- R8: Only the low log2(DEPTH) address bits select a word (DEPTH is a power of two). Addresses that differ only in the upper bits reach the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low chip select |
| sel_p | input | 1 | Active-high chip select |
| wr_n | input | 1 | Active-low write strobe |
| oe_n | input | 1 | Active-low output gate |
| lo_n | input | 1 | Active-low enable, bits 7:0 |
| hi_n | input | 1 | Active-low enable, bits 15:8 |
| addr | input | ADDR_W | Word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data, zero on lanes that are not driving |
| drive_lo | output | 1 | Lane 0 is driving read data |
| drive_hi | output | 1 | Lane 1 is driving read data |

## Verification
A decode fault that picks the wrong mode shows on the drive flags exactly one clock after the sampling edge. A fault that lets a write through in the wrong mode, or onto a masked lane, does not show when it happens. It only appears when that word is read back later, so every blocked write is followed by a read of the same address. Lane swaps and address aliasing show in the first read that uses a lane mask or an aliased address.

// File: rtl/lane_sram_pkg.sv
package lane_sram_pkg;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned N_LANE = 2;

  typedef enum logic [1:0] {
    MODE_OFF = 2'd0,
    MODE_HIZ = 2'd1,
    MODE_RD  = 2'd2,
    MODE_WR  = 2'd3
  } mode_e;
endpackage

// File: rtl/lane_sram_decode.sv
module lane_sram_decode
  import lane_sram_pkg::*;
(
  input  logic              sel_n,
  input  logic              sel_p,
  input  logic              wr_n,
  input  logic              oe_n,
  input  logic              lo_n,
  input  logic              hi_n,
  output mode_e             mode,
  output logic [N_LANE-1:0] lane_on
);
  logic chip_on;

  always_comb begin
    lane_on = {~hi_n, ~lo_n};
    chip_on = ~sel_n & sel_p & (|lane_on);
    if (!chip_on)   mode = MODE_OFF;
    else if (!wr_n) mode = MODE_WR;
    else if (!oe_n) mode = MODE_RD;
    else            mode = MODE_HIZ;
  end
endmodule

// File: rtl/lane_sram_bank.sv
module lane_sram_bank #(
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [BYTE_W-1:0] wbyte,
  output logic [BYTE_W-1:0] rbyte,
  output logic              drive
);
  logic [BYTE_W-1:0] mem [DEPTH];
  logic [BYTE_W-1:0] rbyte_nxt;
  logic              drive_nxt;
  logic              upd_en;

  always_ff @(posedge clk) begin
    if (wr_en) mem[idx] <= wbyte;
  end

  always_comb begin
    upd_en    = rd_en | drive;
    drive_nxt = rd_en;
    rbyte_nxt = rd_en ? mem[idx] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbyte <= '0;
      drive <= 1'b0;
    end else if (upd_en) begin
      rbyte <= rbyte_nxt;
      drive <= drive_nxt;
    end
  end

  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && rd_en)); // R6
  AST_DRIVE_FOLLOWS_RD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> drive); // R4
  AST_QUIET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !drive |-> (rbyte == '0)); // R7
endmodule

// File: rtl/lane_sram.sv
module lane_sram
  import lane_sram_pkg::*;
#(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned DEPTH  = 256,
  localparam int unsigned IDX_W  = $clog2(DEPTH),
  localparam int unsigned DATA_W = N_LANE * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              sel_p,
  input  logic              wr_n,
  input  logic              oe_n,
  input  logic              lo_n,
  input  logic              hi_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              drive_lo,
  output logic              drive_hi
);
  mode_e             mode;
  logic [N_LANE-1:0] lane_on;
  logic [N_LANE-1:0] wr_lane;
  logic [N_LANE-1:0] rd_lane;
  logic [N_LANE-1:0] drv;
  logic [IDX_W-1:0]  idx;

  lane_sram_decode u_dec (
    .sel_n   (sel_n),
    .sel_p   (sel_p),
    .wr_n    (wr_n),
    .oe_n    (oe_n),
    .lo_n    (lo_n),
    .hi_n    (hi_n),
    .mode    (mode),
    .lane_on (lane_on)
  );

  always_comb begin
    idx = IDX_W'(addr % ADDR_W'(DEPTH));
    for (int i = 0; i < N_LANE; i++) begin
      wr_lane[i] = (mode == MODE_WR) && lane_on[i];
      rd_lane[i] = (mode == MODE_RD) && lane_on[i];
    end
  end

  for (genvar g = 0; g < N_LANE; g++) begin : g_lane
    lane_sram_bank #(
      .DEPTH  (DEPTH),
      .BYTE_W (LANE_W)
    ) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_lane[g]),
      .rd_en (rd_lane[g]),
      .idx   (idx),
      .wbyte (wdata[g*LANE_W +: LANE_W]),
      .rbyte (rdata[g*LANE_W +: LANE_W]),
      .drive (drv[g])
    );
  end

  assign drive_lo = drv[0];
  assign drive_hi = drv[1];

  AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_n || !sel_p) |=> (!drive_lo && !drive_hi)); // R1
  AST_NOLANE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_n && hi_n) |=> (!drive_lo && !drive_hi)); // R2
  AST_OUTDIS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_n && oe_n) |=> (!drive_lo && !drive_hi)); // R5
  AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |=> (!drive_lo && !drive_hi)); // R6
  AST_READ_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && sel_p && wr_n && !oe_n && !lo_n) |=> drive_lo); // R4
  AST_READ_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && sel_p && wr_n && !oe_n && !hi_n) |=> drive_hi); // R3
endmodule

// File: tb/sim_lane_sram.sv
module sim_lane_sram;
  localparam int unsigned ADDR_W = 18;
  localparam int unsigned DEPTH  = 256;

  logic clk, rst_n;
  logic sel_n, sel_p, wr_n, oe_n, lo_n, hi_n;
  logic [ADDR_W-1:0] addr;
  logic [15:0] wdata, rdata;
  logic drive_lo, drive_hi;

  int n_run, n_fail;
  logic [15:0] model [DEPTH];

  lane_sram #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sel_p(sel_p), .wr_n(wr_n),
    .oe_n(oe_n), .lo_n(lo_n), .hi_n(hi_n), .addr(addr), .wdata(wdata),
    .rdata(rdata), .drive_lo(drive_lo), .drive_hi(drive_hi)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive one set of controls at the falling edge, sample just after the rising edge.
  task automatic step(input logic s_n, input logic s_p, input logic w_n, input logic o_n,
                      input logic l_n, input logic h_n, input logic [ADDR_W-1:0] a,
                      input logic [15:0] d);
    @(negedge clk);
    sel_n = s_n; sel_p = s_p; wr_n = w_n; oe_n = o_n;
    lo_n = l_n; hi_n = h_n; addr = a; wdata = d;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    step(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, '0, '0);
  endtask

  task automatic wr_full(input logic [ADDR_W-1:0] a, input logic [15:0] d);
    step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, a, d);
    model[a % DEPTH] = d;
  endtask

  task automatic rd_check(input string tag, input logic [ADDR_W-1:0] a,
                          input logic l_n, input logic h_n);
    logic [15:0] exp;
    step(1'b0, 1'b1, 1'b1, 1'b0, l_n, h_n, a, 16'hxxxx);
    exp = model[a % DEPTH];
    if (l_n) exp[7:0] = 8'h00;
    if (h_n) exp[15:8] = 8'h00;
    chk({tag, " data"}, {16'h0, rdata}, {16'h0, exp});
    chk({tag, " flags"}, {30'h0, drive_hi, drive_lo}, {30'h0, ~h_n, ~l_n});
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    sel_n = 1'b1; sel_p = 1'b0; wr_n = 1'b1; oe_n = 1'b1;
    lo_n = 1'b1; hi_n = 1'b1; addr = '0; wdata = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R7 reset data", {16'h0, rdata}, 32'h0);
    chk("R7 reset flags", {30'h0, drive_hi, drive_lo}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_basic();
    wr_full(18'd3, 16'hA55A);
    wr_full(18'd4, 16'h1234);
    wr_full(18'd255, 16'hBEEF);
    rd_check("R4 read a3", 18'd3, 1'b0, 1'b0);
    rd_check("R4 read a4", 18'd4, 1'b0, 1'b0);
    rd_check("R4 read top", 18'd255, 1'b0, 1'b0);
    idle();
    chk("R7 idle after read", {16'h0, rdata}, 32'h0);
  endtask

  task automatic t_lanes();
    // R3: lower-lane write only
    step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 18'd3, 16'hFF11);
    model[3][7:0] = 8'h11;
    rd_check("R3 lo write", 18'd3, 1'b0, 1'b0);
    // R3: upper-lane write only
    step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 18'd4, 16'h77FF);
    model[4][15:8] = 8'h77;
    rd_check("R3 hi write", 18'd4, 1'b0, 1'b0);
    rd_check("R3 lo-only read", 18'd4, 1'b0, 1'b1);
    rd_check("R3 hi-only read", 18'd3, 1'b1, 1'b0);
  endtask

  task automatic t_deselect();
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 18'd3, 16'h0BAD);
    chk("R1 sel_n high flags", {30'h0, drive_hi, drive_lo}, 32'h0);
    rd_check("R1 no write sel_n", 18'd3, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 18'd3, 16'h0BAD);
    chk("R1 sel_p low flags", {30'h0, drive_hi, drive_lo}, 32'h0);
    rd_check("R1 no write sel_p", 18'd3, 1'b0, 1'b0);
    step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 18'd3, '0);
    chk("R1 read blocked", {14'h0, drive_hi, drive_lo, rdata}, 32'h0);
  endtask

  task automatic t_nolane();
    step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 18'd4, 16'hDEAD);
    rd_check("R2 no write", 18'd4, 1'b0, 1'b0);
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 18'd4, '0);
    chk("R2 read blocked", {14'h0, drive_hi, drive_lo, rdata}, 32'h0);
  endtask

  task automatic t_outdis();
    step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 18'd3, 16'h5555);
    chk("R5 quiet", {14'h0, drive_hi, drive_lo, rdata}, 32'h0);
    rd_check("R5 unchanged", 18'd3, 1'b0, 1'b0);
  endtask

  task automatic t_wr_over_oe();
    rd_check("R6 pre read", 18'd9 - 18'd9 + 18'd255, 1'b0, 1'b0);
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 18'd7, 16'hC3C3);
    model[7] = 16'hC3C3;
    chk("R6 flags during write", {30'h0, drive_hi, drive_lo}, 32'h0);
    chk("R6 data during write", {16'h0, rdata}, 32'h0);
    rd_check("R6 written", 18'd7, 1'b0, 1'b0);
  endtask

  task automatic t_alias();
    wr_full(18'd5 + 18'(DEPTH), 16'h6E6E);
    rd_check("R8 alias low", 18'd5, 1'b0, 1'b0);
    rd_check("R8 alias high", 18'h3FF05, 1'b0, 1'b0);
    rd_check("R8 neighbour", 18'd4, 1'b0, 1'b0);
  endtask

  initial begin
    #(4 * 100000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    n_run = 0;
    n_fail = 0;
    t_reset();
    t_basic();
    t_lanes();
    t_deselect();
    t_nolane();
    t_outdis();
    t_wr_over_oe();
    t_alias();
    idle();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule